// File: doc/BRIEF.md
# Serial-bus clock-output control register slave

This block is a slave on a two-wire serial management bus. It oversamples the bus lines with a faster system clock, recovers start and stop conditions, data bits and acknowledge slots, and pulls the data line low through an open-drain enable when it must drive a zero. A host reaches a small bank of 8-bit registers through indexed block transfers. A write carries a starting register index, a byte count and then the data bytes. A read sets the index with a short write phase, then issues a repeated start. The slave then returns the byte count followed by the register contents.

Two of the registers hold per-output enable bits. Each bit gates one of six differential clock output pairs. The remaining bits and bytes are plain storage. After reset every output pair is enabled, so the clock tree runs before any software touches the bus.

Top module: `smb_clkctl_slave`

## Requirements
- R1: After reset all six `out_en` bits are 1 and `sda_oe` is 0. Register 1 reads 0xC0, registers 0 and 2..6 read 0xFF, and the byte count returned by a read is 7.
- R2: The slave acknowledges the address byte 0xD4 (device 0x6A, write) and 0xD5 (device 0x6A, read). Any other address byte gets no acknowledge, and every later byte is ignored with no acknowledge until the next start.
- R3: In a block write, the slave acknowledges the index byte N, the count byte X and each data byte. Data byte k is stored in register N+k, the index increasing by one after every data byte.
- R4: In a block read (0xD4, index N, repeated start, 0xD5), the slave sends the count byte and then registers N, N+1, ... most significant bit first. It sends one further byte after each host acknowledge. After a host NACK it releases the data line until the next start.
- R5: The count byte returned by a read equals the count byte X of the most recent block write whose count was acknowledged, or 7 if none has occurred since reset.
- R6: The enable map is fixed. `out_en[0]` is register 0 bit 7, `out_en[1]` is register 0 bit 6, `out_en[2]` is register 0 bit 3, `out_en[3]` is register 1 bit 6, `out_en[4]` is register 0 bit 0 and `out_en[5]` is register 0 bit 2. A bit value of 1 enables the pair.
- R7: Writes to indices 7 and above are acknowledged and change no register. Reads from indices 7 and above return 0x00.
- R8: A start or stop condition at any point aborts the current transfer. An incomplete data byte is not stored.
- R9: `sda_oe` changes only while the synchronized clock line is low, apart from being released by a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_en | output | 6 | Per-output-pair enables |

## Verification
On every cycle, the embedded assertions check three things. The data-line drive moves only while the clock line is low (R9). A start or stop forces the transfer state back to its entry point (R8). An ignored transfer never drives the line (R2). They also check that an out-of-bank write leaves the enables untouched (R7). Some behaviours show only in the bench's host-driven scenarios. These are the order and content of the count and data bytes in a read (R4, R5), the storage and auto-increment of block writes (R3), the reset contents (R1), the exact bit-to-enable map (R6), and recovery after a bad address or an aborted byte (R2, R8). The bench checks them against a behavioural register model.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGN
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
  } smb_phase_e;

  localparam logic [6:0] DEV_ADDR = 7'h6A;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NREG = 7,
  parameter int IDXW = 8,
  parameter int NOUT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_data,
  output logic [NOUT-1:0] out_en
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);

  function automatic logic [7:0] reset_value(int i);
    return (i == 1) ? 8'hC0 : 8'hFF;
  endfunction

  function automatic int pair_byte(int p);
    return (p == 3) ? 1 : 0;
  endfunction

  function automatic int pair_bit(int p);
    case (p)
      0:       return 7;
      1:       return 6;
      2:       return 3;
      3:       return 6;
      4:       return 0;
      default: return 2;
    endcase
  endfunction

  logic [7:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank[g] <= reset_value(g);
      else if (hit) bank[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDXW'(i)) rd_data = bank[i];
  end

  for (genvar p = 0; p < NOUT; p++) begin : g_en
    assign out_en[p] = bank[pair_byte(p)][pair_bit(p)];
  end

  // R7: a write outside the bank leaves every enable unchanged
  a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx > LAST_IDX)) |=> $stable(out_en));
endmodule

// File: rtl/smb_clkctl_slave.sv
module smb_clkctl_slave #(
  parameter int NREG        = 7,
  parameter int NOUT        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NOUT-1:0] out_en
);
  import smb_pkg::*;

  localparam int IDXW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_state_e st_q, st_d;
  smb_phase_e ph_q, ph_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [7:0]      cnt_q, cnt_d;
  logic            got8_q, got8_d;
  logic            txn_q, txn_d;
  logic            mack_q, mack_d;
  logic            oe_q, oe_d;
  logic            wr_en;
  logic [7:0]      rd_data;

  smb_regbank #(.NREG(NREG), .IDXW(IDXW), .NOUT(NOUT)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx_q), .wr_data(sh_q),
    .rd_idx(idx_q), .rd_data(rd_data), .out_en(out_en)
  );

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q;
    idx_d = idx_q; cnt_d = cnt_q; got8_d = got8_q; txn_d = txn_q;
    mack_d = mack_q; oe_d = oe_q; wr_en = 1'b0;
    if (start_det) begin
      st_d = ST_RX; ph_d = PH_ADDR; bit_d = 3'd0; got8_d = 1'b0; oe_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0; got8_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) got8_d = 1'b1;
          end else if (scl_fall && got8_q) begin
            got8_d = 1'b0;
            st_d   = ST_ACK;
            oe_d   = 1'b1;
            txn_d  = 1'b0;
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  txn_d = sh_q[0];
                  ph_d  = PH_INDEX;
                end else begin
                  st_d = ST_IGN;
                  oe_d = 1'b0;
                end
              end
              PH_INDEX: begin idx_d = sh_q; ph_d = PH_COUNT; end
              PH_COUNT: begin cnt_d = sh_q; ph_d = PH_DATA;  end
              default:  begin wr_en = 1'b1; idx_d = idx_q + 1'b1; end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = 3'd0;
            if (txn_q) begin
              st_d = ST_TX; sh_d = cnt_q; oe_d = ~cnt_q[7];
            end else begin
              st_d = ST_RX; oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              st_d = ST_MACK; oe_d = 1'b0;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 3'd1;
              oe_d  = ~sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_TX; sh_d = rd_data; oe_d = ~rd_data[7];
              bit_d = 3'd0; idx_d = idx_q + 1'b1;
            end else begin
              st_d = ST_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= PH_ADDR; bit_q <= 3'd0; sh_q <= 8'h00;
      idx_q <= '0; cnt_q <= 8'(NREG); got8_q <= 1'b0; txn_q <= 1'b0;
      mack_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      idx_q <= idx_d; cnt_q <= cnt_d; got8_q <= got8_d; txn_q <= txn_d;
      mack_q <= mack_d; oe_q <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R9: data-line drive moves only while the clock line is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oe_q) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R8: a start re-enters address reception
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_RX) && (ph_q == PH_ADDR) && (bit_q == 3'd0) && !oe_q);

  // R8: a stop returns to idle with the line released
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st_q == ST_IDLE) && !oe_q);

  // R2: an ignored transfer never pulls the line
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN) |-> !oe_q);
endmodule

// File: tb/test_smb_clkctl_slave.sv
module test_smb_clkctl_slave;
  localparam int Q = 8;
  localparam int NREG = 7;

  logic clk, rst_n, scl, sda_h;
  logic sda_oe;
  logic [5:0] out_en;
  wire sda_line = sda_h & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  logic [7:0] mdl [NREG];
  int mcnt;

  smb_clkctl_slave i_smb_clkctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .out_en(out_en)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [5:0] exp_en();
    return {mdl[0][2], mdl[0][0], mdl[1][6], mdl[0][3], mdl[0][6], mdl[0][7]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Continuous comparison of the enables against the model (R6)
  always @(negedge clk) if (cmp_on) check("R6 enables vs model", out_en, exp_en());

  // R9: the drive must not change while the clock line is high
  logic oe_prev;
  always @(negedge clk) begin
    if (rst_n && cmp_on && (sda_oe !== oe_prev) && scl)
      check("R9 drive changed with clock high", 1, 0);
    oe_prev = sda_oe;
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_h = 1; hq(); scl = 1; hq(); sda_h = 0; hq(); scl = 0; hq(); endtask
  task automatic bus_stop(); sda_h = 0; hq(); scl = 1; hq(); sda_h = 1; hq(); hq(); endtask
  task automatic bit_io(input logic b, output logic r);
    sda_h = b; hq(); scl = 1; hq(); r = sda_line; hq(); scl = 0; hq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(~give_ack, r);
  endtask

  task automatic write_block(input int n, input logic [7:0] d[$]);
    logic a;
    cmp_on = 0;
    bus_start();
    send_byte(8'hD4, a); check("R2 ack write address", a, 1);
    send_byte(8'(n), a); check("R3 ack index", a, 1);
    send_byte(8'(d.size()), a); check("R3 ack count", a, 1);
    mcnt = d.size();
    foreach (d[k]) begin
      send_byte(d[k], a); check("R3/R7 ack data", a, 1);
      if (n + k < NREG) mdl[n + k] = d[k];
    end
    bus_stop();
    cmp_on = 1;
  endtask

  task automatic read_block(input int n, input int len);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, a); check("R2 ack write address", a, 1);
    send_byte(8'(n), a); check("R3 ack index", a, 1);
    bus_start();
    send_byte(8'hD5, a); check("R2 ack read address", a, 1);
    recv_byte(b, 1'b1); check("R5 returned count", b, mcnt);
    for (int k = 0; k < len; k++) begin
      recv_byte(b, k != len - 1);
      check((n + k < NREG) ? "R4 read data" : "R7 read beyond bank",
            b, (n + k < NREG) ? mdl[n + k] : 0);
    end
    check("R4 line released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic r;
    scl = 1; sda_h = 1; rst_n = 0;
    for (int i = 0; i < NREG; i++) mdl[i] = (i == 1) ? 8'hC0 : 8'hFF;
    mcnt = NREG;
    repeat (5) @(negedge clk);
    check("R1 reset enables", out_en, 6'h3F);
    check("R1 reset drive", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cmp_on = 1;
    read_block(0, 7);                          // R1 defaults, R4, R5

    write_block(0, '{8'h00});                  // R6: only pair 3 left on
    check("R6 byte0 cleared", out_en, 6'b001000);
    write_block(0, '{8'h80}); check("R6 bit7 -> pair0", out_en, 6'b001001);
    write_block(0, '{8'h40}); check("R6 bit6 -> pair1", out_en, 6'b001010);
    write_block(0, '{8'h08}); check("R6 bit3 -> pair2", out_en, 6'b001100);
    write_block(0, '{8'h01}); check("R6 bit0 -> pair4", out_en, 6'b011000);
    write_block(0, '{8'h04}); check("R6 bit2 -> pair5", out_en, 6'b101000);
    write_block(1, '{8'h00}); check("R6 byte1 bit6 -> pair3", out_en, 6'b100000);

    write_block(2, '{8'h11, 8'h22, 8'h33});    // R3 auto-increment
    read_block(1, 4);                          // R4, R5 count 3

    write_block(5, '{8'hAA, 8'hBB, 8'hCC, 8'hDD}); // R7 write beyond bank
    read_block(5, 4);                          // R7 reads 0x00 past end

    // R2: foreign address is refused and the rest of the transfer ignored
    cmp_on = 0;
    bus_start();
    send_byte(8'hA0, a); check("R2 foreign address NACK", a, 0);
    send_byte(8'h00, a); check("R2 ignored byte NACK", a, 0);
    send_byte(8'h00, a); check("R2 ignored byte NACK", a, 0);
    bus_stop();
    cmp_on = 1;
    check("R2 enables unchanged after ignored transfer", out_en, exp_en());

    // R8: a start in the middle of a data byte aborts it
    cmp_on = 0;
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    mcnt = 1;
    for (int i = 0; i < 4; i++) bit_io(1'b0, r);
    bus_start();
    bus_stop();
    cmp_on = 1;
    check("R8 enables unchanged after abort", out_en, exp_en());
    read_block(0, 2);                          // R8 byte 0 kept old value

    write_block(0, '{8'hFF, 8'hC0});           // restore defaults
    check("R6 all enabled again", out_en, 6'h3F);

    cmp_on = 0;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule